// File: doc/BRIEF.md
# Tuner Frequency-Change Sequencer

This block runs the automatic frequency-change sequences of a radio tuner. A start strobe, together with a 3-bit mode code, launches a sequence. The sequence moves the synthesizer to a second, pre-loaded set of frequency registers and, where the mode requires it, moves back again. While it runs, the block can wait for the synthesizer to report lock and count programmable mute or acquisition intervals.

The block also drives two handshake lines to a downstream audio processor. The sample line marks a mute window, a quality-acquisition window, or permission to restart or freeze quality processing. The hold line asks the processor to mute and hold its processing. Both lines model open-drain pins: a 0 means the line is pulled low (asserted) and a 1 means it is released. A bank-select output and a one-cycle reload strobe steer the synthesizer. Busy, done and a sticky lock-timeout bit report the progress of a sequence.

Top module: `tune_seq`

## Requirements
- R1: Mode code 0 is no action. A start with mode 0 changes no output: busy, done, reload, bank, flags and timeout keep their values.
- R2: A start is accepted while the block is idle and the mode is not 0. For modes 1 to 6, the cycle after the accepting edge shows bank_sel_o inverted and reload_o high for exactly one cycle. bank_sel_o changes only together with reload_o.
- R3: A lock wait ends in the cycle where lock_i is high. If lock_i stays low, it ends after lock_wait_i+1 cycles, and timeout_o is then set. timeout_o stays set until the next accepted start, which clears it.
- R4: Mode 1 (preset): swap, lock wait, then a mute interval of max(mute_wait_i,1) cycles. sample_n_o is low for the lock wait and the mute interval. hold_n_o is low for the mute interval only.
- R5: Mode 2 (search): swap, lock wait, finish. sample_n_o is low during the lock wait and stays low after done.
- R6: Mode 3 (AF update): swap, lock wait, then an acquisition interval of max(af_wait_i,1) cycles with sample_n_o low. It then swaps back with a second reload, runs a second lock wait and finishes. hold_n_o is low for the whole sequence and is released at done.
- R7: Mode 4 (jump): swap, lock wait, then max(af_wait_i,1) cycles with sample_n_o low (quality may restart). hold_n_o is low throughout. Both lines are released at done.
- R8: Mode 5 (check): swap, lock wait, finish. hold_n_o is low during the lock wait. After done, both lines stay low (muted, quality frozen).
- R9: Mode 6 (load) swaps the bank with one reload and finishes at once. Mode 7 (end) finishes at once with no reload. Neither raises busy, and both release any persistent flags.
- R10: A start that arrives while busy is ignored. The running sequence keeps its length, flags and reload count.
- R11: done_o pulses high for one cycle after each accepted sequence ends, never while busy_o is high. Any accepted start releases the lines left low by an earlier search or check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| mode_i | input | 3 | Mode code: 0 nil, 1 preset, 2 search, 3 AF update, 4 jump, 5 check, 6 load, 7 end |
| lock_i | input | 1 | Synthesizer lock indication |
| lock_wait_i | input | LW_W | Lock-wait limit in cycles |
| mute_wait_i | input | TW_W | Preset mute interval in cycles |
| af_wait_i | input | TW_W | Acquisition interval in cycles |
| bank_sel_o | output | 1 | Active frequency register bank |
| reload_o | output | 1 | One-cycle synthesizer reload strobe |
| sample_n_o | output | 1 | Sample handshake line, 0 = pulled low |
| hold_n_o | output | 1 | Hold handshake line, 0 = pulled low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| timeout_o | output | 1 | Sticky lock-timeout status |

## Verification
The bench builds the block with its defaults, LW_W=4 and TW_W=4, and holds the lock-wait limit at 4. With these values every lock wait ends within five cycles, so the bench can sweep all eight modes against lock delays of 0, 2, 4 and 5 cycles. It crosses these with mute and acquisition settings of 0, short and long. This covers both the lock-seen and the timeout exits, the zero-wait clamp, and the persistence of the lines across sequences. The bench also injects starts during long sequences to show that they are ignored.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  typedef enum logic [2:0] {
    MD_NIL, MD_PRESET, MD_SEARCH, MD_AF, MD_JUMP, MD_CHECK, MD_LOAD, MD_END
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOCK, S_MUTE, S_AFW, S_LOCK2
  } state_e;
endpackage

// File: rtl/tseq_timer.sv
module tseq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '0;
    else if (clr_i)      cnt_o <= '0;
    else if (cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tseq_bank.sv
module tseq_bank (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic bank_o,
  output logic reload_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o   <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      reload_o <= toggle_i;
      if (toggle_i) bank_o <= ~bank_o;
    end
  end
endmodule

// File: rtl/tseq_flags.sv
module tseq_flags
  import tseq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_e st_i,
  input  mode_e  mode_i,
  input  logic   clr_i,
  input  logic   set_s_i,
  input  logic   set_h_i,
  output logic   sample_n_o,
  output logic   hold_n_o
);
  logic ps_q, ph_q;
  logic s_act, h_act, hold_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= 1'b0;
      ph_q <= 1'b0;
    end else if (clr_i) begin
      ps_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      if (set_s_i) ps_q <= 1'b1;
      if (set_h_i) ph_q <= 1'b1;
    end
  end

  assign hold_mode = (mode_i == MD_AF) || (mode_i == MD_JUMP) || (mode_i == MD_CHECK);

  always_comb begin
    s_act = ps_q;
    if (st_i == S_LOCK && (mode_i == MD_PRESET || mode_i == MD_SEARCH)) s_act = 1'b1;
    if (st_i == S_MUTE) s_act = 1'b1;
    if (st_i == S_AFW)  s_act = 1'b1;
    h_act = ph_q || (st_i == S_MUTE) || (hold_mode && st_i != S_IDLE);
  end

  assign sample_n_o = ~s_act;
  assign hold_n_o   = ~h_act;

  // lines left low only by a finished search or check
  p_persist_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ps_q && !ph_q));
endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tseq_pkg::*;
#(
  parameter int LW_W = 4,
  parameter int TW_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic            lock_i,
  input  logic [LW_W-1:0] lock_wait_i,
  input  logic [TW_W-1:0] mute_wait_i,
  input  logic [TW_W-1:0] af_wait_i,
  output logic            bank_sel_o,
  output logic            reload_o,
  output logic            sample_n_o,
  output logic            hold_n_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            timeout_o
);
  localparam int CW = (LW_W > TW_W) ? LW_W : TW_W;
  localparam int EW = CW + 1;

  state_e st_q, st_d;
  mode_e  mode_q, mode_in;
  logic   accept, toggle, fin, to_hit, set_s, set_h, clr_cnt;
  logic   lock_exp, mute_exp, af_exp;
  logic [CW-1:0] cnt;
  logic [EW-1:0] cnt_x, cnt_n;

  assign mode_in = mode_e'(mode_i);
  assign accept  = start_i && (st_q == S_IDLE) && (mode_in != MD_NIL);
  assign busy_o  = (st_q != S_IDLE);

  assign cnt_x    = EW'(cnt);
  assign cnt_n    = cnt_x + EW'(1);
  assign lock_exp = cnt_x >= EW'(lock_wait_i);
  assign mute_exp = cnt_n >= EW'(mute_wait_i);
  assign af_exp   = cnt_n >= EW'(af_wait_i);

  always_comb begin
    st_d   = st_q;
    toggle = 1'b0;
    fin    = 1'b0;
    to_hit = 1'b0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        case (mode_in)
          MD_LOAD: begin toggle = 1'b1; fin = 1'b1; end
          MD_END:  fin = 1'b1;
          default: begin toggle = 1'b1; st_d = S_LOCK; end
        endcase
      end
      S_LOCK: if (lock_i || lock_exp) begin
        to_hit = !lock_i;
        case (mode_q)
          MD_PRESET:     st_d = S_MUTE;
          MD_AF, MD_JUMP: st_d = S_AFW;
          default: begin st_d = S_IDLE; fin = 1'b1; end
        endcase
      end
      S_MUTE: if (mute_exp) begin st_d = S_IDLE; fin = 1'b1; end
      S_AFW: if (af_exp) begin
        if (mode_q == MD_AF) begin st_d = S_LOCK2; toggle = 1'b1; end
        else begin st_d = S_IDLE; fin = 1'b1; end
      end
      S_LOCK2: if (lock_i || lock_exp) begin
        to_hit = !lock_i;
        st_d   = S_IDLE;
        fin    = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign set_s   = fin && busy_o && (mode_q == MD_SEARCH || mode_q == MD_CHECK);
  assign set_h   = fin && busy_o && (mode_q == MD_CHECK);
  assign clr_cnt = accept || (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      mode_q    <= MD_NIL;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin;
      if (accept) begin
        mode_q    <= mode_in;
        timeout_o <= 1'b0;
      end else if (to_hit) begin
        timeout_o <= 1'b1;
      end
    end
  end

  tseq_timer #(.W(CW)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr_cnt), .cnt_o(cnt)
  );

  tseq_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .toggle_i(toggle),
    .bank_o(bank_sel_o), .reload_o(reload_o)
  );

  tseq_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_q), .mode_i(mode_q),
    .clr_i(accept), .set_s_i(set_s), .set_h_i(set_h),
    .sample_n_o(sample_n_o), .hold_n_o(hold_n_o)
  );

  p_nil_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mode_i == 3'd0) |=> (!busy_o && !reload_o && !done_o));

  p_reload_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_o && st_q != S_LOCK2) |=> !reload_o);

  p_bank_with_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_sel_o) |-> reload_o);

  p_lock_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOCK || st_q == S_LOCK2) |-> (cnt_x <= EW'(lock_wait_i)));

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (mode_q == $past(mode_q)));

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/tune_seq_tb_top.sv
module tune_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode = 3'd0;
  logic lock = 1'b1;
  logic [3:0] lock_wait = 4'd4;
  logic [3:0] mute_wait = 4'd0;
  logic [3:0] af_wait = 4'd0;
  logic bank, reload, sample_n, hold_n, busy, done, tout;

  int checks = 0;
  int fails = 0;
  int dly = 0;
  int since = 100;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tune_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .lock_i(lock),
    .lock_wait_i(lock_wait), .mute_wait_i(mute_wait), .af_wait_i(af_wait),
    .bank_sel_o(bank), .reload_o(reload), .sample_n_o(sample_n), .hold_n_o(hold_n),
    .busy_o(busy), .done_o(done), .timeout_o(tout)
  );

  // lock rises dly cycles after each reload
  always @(negedge clk) begin
    if (reload) since = 0;
    else if (since < 100) since = since + 1;
    lock = (since >= dly);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int exp_bank = 0, exp_to = 0, exp_ps = 0, exp_ph = 0;

  task automatic run(input int m, input int d, input int mw, input int aw);
    int lp, mm, aa, b, s, h, r, tov, tag_b;
    int nb = 0, ns = 0, nh = 0, nr = 0, nd = 0;
    bit inj;
    string rq;
    lp = ((d < 4) ? d : 4) + 1;
    mm = (mw < 1) ? 1 : mw;
    aa = (aw < 1) ? 1 : aw;
    tov = (d > 4) ? 1 : 0;
    case (m)
      1: begin b = lp + mm; s = lp + mm; h = mm; r = 1; rq = "R4"; end
      2: begin b = lp; s = lp; h = 0; r = 1; rq = "R5"; end
      3: begin b = 2*lp + aa; s = aa; h = b; r = 2; rq = "R6"; end
      4: begin b = lp + aa; s = aa; h = b; r = 1; rq = "R7"; end
      5: begin b = lp; s = 0; h = lp; r = 1; rq = "R8"; end
      6: begin b = 0; s = 0; h = 0; r = 1; rq = "R9"; end
      7: begin b = 0; s = 0; h = 0; r = 0; rq = "R9"; end
      default: begin b = 0; s = 0; h = 0; r = 0; rq = "R1"; end
    endcase
    inj = (b >= 3) && (d == 2);
    dly = d; mute_wait = 4'(mw); af_wait = 4'(aw);
    @(negedge clk);
    mode = 3'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (busy) begin
        nb++;
        if (!sample_n) ns++;
        if (!hold_n) nh++;
      end
      if (reload) nr++;
      if (done) begin nd++; chk("R11", "done while busy", int'(busy), 0); end
      if (c == 0 && m >= 1 && m <= 6) chk("R2", "reload after accept", int'(reload), 1);
      if (inj && c == 1) begin start = 1'b1; mode = 3'(m ^ 1); end   // R10 injected start
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    tag_b = b;
    if (m != 0) begin
      exp_to = (m <= 5) ? tov : 0;
      exp_ps = (m == 2 || m == 5) ? 1 : 0;
      exp_ph = (m == 5) ? 1 : 0;
    end
    exp_bank = exp_bank ^ (r & 1);
    chk(inj ? "R10" : rq, "busy cycles", nb, tag_b);
    chk(rq, "sample low cycles", ns, s);
    chk(rq, "hold low cycles", nh, h);
    chk("R2", "reload count", nr, r);
    chk("R11", "done pulses", nd, (m != 0) ? 1 : 0);
    chk("R3", "timeout", int'(tout), exp_to);
    chk("R2", "bank", int'(bank), exp_bank);
    chk((m == 2) ? "R5" : "R8", "sample idle", int'(!sample_n), exp_ps);
    chk((m == 5) ? "R8" : "R11", "hold idle", int'(!hold_n), exp_ph);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int dl[4] = '{0, 2, 4, 5};
    int mv[3] = '{0, 2, 5};
    int av[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", int'(busy), 0);
    chk("R11", "reset done", int'(done), 0);
    chk("R2", "reset bank", int'(bank), 0);
    chk("R2", "reset reload", int'(reload), 0);
    chk("R3", "reset timeout", int'(tout), 0);
    chk("R11", "reset sample", int'(sample_n), 1);
    chk("R11", "reset hold", int'(hold_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int di = 0; di < 4; di++)
        for (int mi = 0; mi < 3; mi++)
          for (int ai = 0; ai < 3; ai++)
            run(m, dl[di], mv[mi], av[ai]);
    // persistence then nil, then end releases
    run(5, 5, 0, 0);
    run(0, 0, 0, 0);
    run(2, 1, 0, 0);
    run(7, 0, 0, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule